// File: doc/BRIEF.md
# System Control Register with Interrupt Aggregation

This block holds one 32-bit system control/status word for a small multiprocessor board. It gathers up to 32 external interrupt request lines into that word, one bit per line. It drives a processor interrupt output that is gated by an enable bit. It also runs a periodic timer interrupt, and software acknowledges that interrupt by writing the word. A second, separate window on the same register bus holds a single interrupt vector register. Software uses it to leave and fetch the code of the interrupt being serviced, for example 0xFC for a transmit event, 0xF8 for a receive event and 0x80 for an inter-processor interrupt.

Software reaches the block through a simple request bus. The top address bit chooses the vector window (1) or the control window (0). Inside the control window, only offset zero holds a register. Every access to the control window also records the requesting processor's ID in the low bits of the word. Bit 16 of every control-word read is flipped by a pseudo-random bit, so software that polls it sees it change. The bench can predict this bit because the generator is a seeded LFSR.

Top module: `syscsr_ctrl`

## Requirements
- R1: After reset the control word, the vector register, `cpu_irq`, `timer_irq`, `rd_valid` and `rd_data` are all zero. The jitter generator starts at its `JIT_SEED` parameter.
- R2: A pulse on `line_set[n]` sets control bit n, and a pulse on `line_clr[n]` clears it. The new value is visible to reads from the next cycle on.
- R3: When a line set pulse leaves control bit 28 (interrupt enable) at 1 after the update, `cpu_irq` is 1 from the next cycle on. With bit 28 at 0, a set pulse leaves `cpu_irq` unchanged.
- R4: When a line clear pulse leaves bit 28 at 0 after the update, `cpu_irq` goes to 0. A clear pulse with bit 28 at 1 leaves `cpu_irq` unchanged, and so does a cycle with no line pulse, even one that writes bit 28.
- R5: On a `tick` pulse while control bit 15 (timer enable) is 1, bit 29 (timer pending) and `timer_irq` become 1 in the next cycle. With bit 15 at 0, a tick changes nothing.
- R6: A write to control offset 0 loads the whole word from `req_wdata`, then forces bit 29 to 0 and drops `timer_irq`, whatever value was written.
- R7: When a tick and a control write arrive in the same cycle, the write wins: bit 29 and `timer_irq` are 0 afterwards.
- R8: Every control-window access first replaces bits 3:0 of the word with `cpu_id`. A read therefore returns the current ID in those bits, while a write at offset 0 then overwrites them with its own data.
- R9: A read of offset 0 returns the word with bit 16 XORed with bit 0 of a 16-bit Galois LFSR. The LFSR shifts right with feedback mask 0xB400 and advances exactly once per such read.
- R10: A write to the vector window (`req_addr` top bit 1) stores `req_wdata`. A read there returns the last value stored and leaves the control word unchanged.
- R11: Reads of control-window offsets other than 0 return zero. Writes to those offsets leave the word unchanged apart from the ID capture of R8.
- R12: Each read request produces `rd_valid` with its data exactly one cycle later. Writes and idle cycles produce no `rd_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Bus request this cycle |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W (13) | Byte address; top bit selects the vector window |
| req_wdata | input | 32 | Write data |
| rd_valid | output | 1 | Read data valid, one cycle after a read request |
| rd_data | output | 32 | Read data |
| line_set | input | NLINES (32) | One-cycle assert pulses per interrupt line |
| line_clr | input | NLINES (32) | One-cycle deassert pulses per interrupt line |
| cpu_id | input | ID_W (4) | ID of the processor making the current request |
| tick | input | 1 | Timer tick strobe |
| cpu_irq | output | 1 | Processor interrupt output |
| timer_irq | output | 1 | Timer interrupt output |

## Verification
The assertions take for granted that a given line never receives a set pulse and a clear pulse in the same cycle. They also take for granted that a read result is only looked at when `rd_valid` is high. The stimulus keeps to both rules: each line pulse pattern drives disjoint set and clear masks, and the scoreboard only pops expected values on `rd_valid`. Bus operations are separated by at least one idle cycle. Ticks are issued alone, except for the one deliberate tick-plus-write collision, so that every expected value follows from one event at a time.

// File: rtl/syscsr_pkg.sv
package syscsr_pkg;

  localparam int CSR_W        = 32;
  localparam int LFSR_W       = 16;
  localparam int BIT_TMR_EN   = 15;
  localparam int BIT_JITTER   = 16;
  localparam int BIT_IRQ_EN   = 28;
  localparam int BIT_TMR_PEND = 29;
  localparam logic [LFSR_W-1:0] LFSR_TAPS = 16'hB400;

  typedef logic [CSR_W-1:0] csr_word_t;

  // One right-shift step of the Galois jitter generator.
  function automatic logic [LFSR_W-1:0] lfsr_step(input logic [LFSR_W-1:0] s);
    return (s >> 1) ^ ({LFSR_W{s[0]}} & LFSR_TAPS);
  endfunction

  // Line pulses applied on top of a word: clears first, then sets.
  function automatic csr_word_t apply_lines(input csr_word_t w,
                                            input csr_word_t set_m,
                                            input csr_word_t clr_m);
    return (w & ~clr_m) | set_m;
  endfunction

  // Processor interrupt next state from the freshly updated word.
  function automatic logic cpu_irq_next(input logic cur,
                                        input logic any_set,
                                        input logic any_clr,
                                        input logic en_after);
    logic n;
    n = cur;
    if (any_set && en_after)
      n = 1'b1;
    else if (any_clr && !en_after)
      n = 1'b0;
    return n;
  endfunction

endpackage

// File: rtl/syscsr_decode.sv
module syscsr_decode #(
  parameter int ADDR_W = 13
) (
  input  logic              req_valid,
  input  logic              req_we,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              ctl_touch,
  output logic              csr_rd,
  output logic              csr_wr,
  output logic              vec_rd,
  output logic              vec_wr
);
  localparam int OFF_W = ADDR_W - 1;

  logic in_vec;
  logic at_zero;

  assign in_vec  = req_addr[ADDR_W-1];
  assign at_zero = (req_addr[OFF_W-1:0] == '0);

  assign ctl_touch = req_valid && !in_vec;
  assign csr_rd    = ctl_touch && at_zero && !req_we;
  assign csr_wr    = ctl_touch && at_zero &&  req_we;
  assign vec_rd    = req_valid && in_vec && !req_we;
  assign vec_wr    = req_valid && in_vec &&  req_we;
endmodule

// File: rtl/syscsr_lfsr.sv
module syscsr_lfsr
  import syscsr_pkg::*;
#(
  parameter logic [LFSR_W-1:0] SEED = 16'hACE1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adv,
  output logic [LFSR_W-1:0] state
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      state <= SEED;
    else if (adv)
      state <= lfsr_step(state);
  end
endmodule

// File: rtl/syscsr_core.sv
module syscsr_core
  import syscsr_pkg::*;
#(
  parameter int NLINES = 32,
  parameter int ID_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NLINES-1:0] line_set,
  input  logic [NLINES-1:0] line_clr,
  input  logic              tick,
  input  logic              ctl_touch,
  input  logic              csr_wr,
  input  csr_word_t         wdata,
  input  logic [ID_W-1:0]   cpu_id,
  output csr_word_t         csr_q,
  output logic              cpu_irq,
  output logic              timer_irq,
  output logic              tick_hit
);
  localparam int PAD = CSR_W - NLINES;

  csr_word_t set_w, clr_w, nxt;
  logic      cirq_n, tirq_n;

  generate
    if (PAD > 0) begin : g_pad
      assign set_w = {{PAD{1'b0}}, line_set};
      assign clr_w = {{PAD{1'b0}}, line_clr};
    end else begin : g_full
      assign set_w = line_set;
      assign clr_w = line_clr;
    end
  endgenerate

  assign tick_hit = tick && csr_q[BIT_TMR_EN];

  always_comb begin
    nxt = csr_q;
    if (ctl_touch)
      nxt[ID_W-1:0] = cpu_id;
    if (csr_wr)
      nxt = wdata;
    nxt = apply_lines(nxt, set_w, clr_w);
    if (tick_hit)
      nxt[BIT_TMR_PEND] = 1'b1;
    if (csr_wr)
      nxt[BIT_TMR_PEND] = 1'b0;

    cirq_n = cpu_irq_next(cpu_irq, |set_w, |clr_w, nxt[BIT_IRQ_EN]);

    tirq_n = timer_irq;
    if (tick_hit)
      tirq_n = 1'b1;
    if (csr_wr)
      tirq_n = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      csr_q     <= '0;
      cpu_irq   <= 1'b0;
      timer_irq <= 1'b0;
    end else begin
      csr_q     <= nxt;
      cpu_irq   <= cirq_n;
      timer_irq <= tirq_n;
    end
  end
endmodule

// File: rtl/syscsr_vecwin.sv
module syscsr_vecwin #(
  parameter int VEC_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [VEC_W-1:0] wdata,
  output logic [VEC_W-1:0] vec_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      vec_q <= '0;
    else if (wr)
      vec_q <= wdata;
  end
endmodule

// File: rtl/syscsr_ctrl.sv
module syscsr_ctrl
  import syscsr_pkg::*;
#(
  parameter int                ADDR_W   = 13,
  parameter int                NLINES   = 32,
  parameter int                ID_W     = 4,
  parameter logic [LFSR_W-1:0] JIT_SEED = 16'hACE1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_we,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [CSR_W-1:0]  req_wdata,
  output logic              rd_valid,
  output logic [CSR_W-1:0]  rd_data,
  input  logic [NLINES-1:0] line_set,
  input  logic [NLINES-1:0] line_clr,
  input  logic [ID_W-1:0]   cpu_id,
  input  logic              tick,
  output logic              cpu_irq,
  output logic              timer_irq
);
  // Named internal events, also observed by the bound checker.
  logic              ev_ctl_touch;
  logic              ev_csr_rd;
  logic              ev_csr_wr;
  logic              ev_vec_rd;
  logic              ev_vec_wr;
  logic              ev_tick_hit;
  csr_word_t         csr_q;
  csr_word_t         vec_q;
  logic [LFSR_W-1:0] lfsr_q;
  csr_word_t         csr_view;
  csr_word_t         rd_next;

  syscsr_decode #(.ADDR_W(ADDR_W)) u_dec (
    .req_valid (req_valid),
    .req_we    (req_we),
    .req_addr  (req_addr),
    .ctl_touch (ev_ctl_touch),
    .csr_rd    (ev_csr_rd),
    .csr_wr    (ev_csr_wr),
    .vec_rd    (ev_vec_rd),
    .vec_wr    (ev_vec_wr)
  );

  syscsr_core #(.NLINES(NLINES), .ID_W(ID_W)) u_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .line_set  (line_set),
    .line_clr  (line_clr),
    .tick      (tick),
    .ctl_touch (ev_ctl_touch),
    .csr_wr    (ev_csr_wr),
    .wdata     (req_wdata),
    .cpu_id    (cpu_id),
    .csr_q     (csr_q),
    .cpu_irq   (cpu_irq),
    .timer_irq (timer_irq),
    .tick_hit  (ev_tick_hit)
  );

  syscsr_lfsr #(.SEED(JIT_SEED)) u_jit (
    .clk   (clk),
    .rst_n (rst_n),
    .adv   (ev_csr_rd),
    .state (lfsr_q)
  );

  syscsr_vecwin #(.VEC_W(CSR_W)) u_vec (
    .clk   (clk),
    .rst_n (rst_n),
    .wr    (ev_vec_wr),
    .wdata (req_wdata),
    .vec_q (vec_q)
  );

  // Read view: ID forced in the low bits, jitter on bit 16.
  always_comb begin
    csr_view               = csr_q;
    csr_view[ID_W-1:0]     = cpu_id;
    csr_view[BIT_JITTER]   = csr_q[BIT_JITTER] ^ lfsr_q[0];
    rd_next                = '0;
    if (ev_csr_rd)
      rd_next = csr_view;
    else if (ev_vec_rd)
      rd_next = vec_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= req_valid && !req_we;
      rd_data  <= rd_next;
    end
  end
endmodule

// File: rtl/syscsr_ctrl_chk.sv
module syscsr_ctrl_chk
  import syscsr_pkg::*;
#(
  parameter int NLINES = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_we,
  input logic              rd_valid,
  input logic [NLINES-1:0] line_set,
  input logic [NLINES-1:0] line_clr,
  input logic              cpu_irq,
  input logic              timer_irq,
  input csr_word_t         csr_q,
  input logic [LFSR_W-1:0] lfsr_q,
  input logic              ev_csr_rd,
  input logic              ev_csr_wr,
  input logic              ev_tick_hit
);
  assert_line_raise_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (|line_set) |=> (!csr_q[BIT_IRQ_EN] || cpu_irq));

  assert_line_drop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (|line_clr) |=> (csr_q[BIT_IRQ_EN] || !cpu_irq));

  assert_irq_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!(|line_set) && !(|line_clr)) |=> $stable(cpu_irq));

  assert_timer_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_tick_hit && !ev_csr_wr) |=> (timer_irq && csr_q[BIT_TMR_PEND]));

  assert_timer_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!ev_tick_hit && !ev_csr_wr) |=> $stable(timer_irq));

  // R6 and R7: a write clears the pending state even against a tick.
  assert_write_ack_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_csr_wr |=> (!timer_irq && !csr_q[BIT_TMR_PEND]));

  assert_lfsr_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !ev_csr_rd |=> $stable(lfsr_q));

  assert_lfsr_live_R9: assert property (@(posedge clk) disable iff (!rst_n)
    lfsr_q != '0);

  assert_rd_latency_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_we) |=> rd_valid);

  assert_no_spurious_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && !req_we) |=> !rd_valid);
endmodule

bind syscsr_ctrl syscsr_ctrl_chk #(.NLINES(NLINES)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_valid   (req_valid),
  .req_we      (req_we),
  .rd_valid    (rd_valid),
  .line_set    (line_set),
  .line_clr    (line_clr),
  .cpu_irq     (cpu_irq),
  .timer_irq   (timer_irq),
  .csr_q       (csr_q),
  .lfsr_q      (lfsr_q),
  .ev_csr_rd   (ev_csr_rd),
  .ev_csr_wr   (ev_csr_wr),
  .ev_tick_hit (ev_tick_hit)
);

// File: tb/syscsr_ctrl_tb.sv
`timescale 1ns/1ps
module syscsr_ctrl_tb;
  localparam int          AW   = 13;
  localparam logic [15:0] SEED = 16'h1D2B;
  localparam logic [AW-1:0] A_CSR = 13'h0000;
  localparam logic [AW-1:0] A_GAP = 13'h0004;
  localparam logic [AW-1:0] A_VEC = 13'h1000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0, req_we = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [31:0]   req_wdata = '0;
  logic          rd_valid;
  logic [31:0]   rd_data;
  logic [31:0]   line_set = '0, line_clr = '0;
  logic [3:0]    cpu_id = 4'h0;
  logic          tick = 1'b0;
  logic          cpu_irq, timer_irq;

  always #2.5 clk = ~clk;

  syscsr_ctrl #(.ADDR_W(AW), .JIT_SEED(SEED)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_we(req_we),
    .req_addr(req_addr), .req_wdata(req_wdata), .rd_valid(rd_valid),
    .rd_data(rd_data), .line_set(line_set), .line_clr(line_clr),
    .cpu_id(cpu_id), .tick(tick), .cpu_irq(cpu_irq), .timer_irq(timer_irq)
  );

  int checks = 0, failures = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  // Bench model of the requirements.
  logic [31:0] m_csr = '0, m_vec = '0;
  logic [15:0] m_lfsr = SEED;
  logic        m_cirq = 1'b0, m_tirq = 1'b0;

  function automatic logic [15:0] tb_lfsr_adv(logic [15:0] s);
    logic [15:0] n;
    n = {1'b0, s[15:1]};
    if (s[0]) begin
      n[15] = ~n[15]; n[13] = ~n[13]; n[12] = ~n[12]; n[10] = ~n[10];
    end
    return n;
  endfunction

  task automatic check(input logic ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Monitor: pops expected read data on every rd_valid.
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && rd_valid) begin
        if (exp_q.size() == 0)
          check(1'b0, "R12 unexpected rd_valid", 32'h1, 32'h0);
        else begin
          logic [31:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(rd_data === e, t, rd_data, e);
        end
      end
    end
  end

  task automatic bus(input logic we, input logic [AW-1:0] a, input logic [31:0] d,
                     input logic with_tick);
    @(posedge clk); #1;
    req_valid = 1'b1; req_we = we; req_addr = a; req_wdata = d; tick = with_tick;
    @(posedge clk); #1;
    req_valid = 1'b0; req_we = 1'b0; tick = 1'b0;
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    if (a[AW-1]) m_vec = d;
    else if (a[AW-2:0] == '0) begin
      m_csr = d; m_csr[29] = 1'b0; m_tirq = 1'b0;
    end else m_csr[3:0] = cpu_id;
    bus(1'b1, a, d, 1'b0);
  endtask

  task automatic rd(input logic [AW-1:0] a, input string t);
    logic [31:0] e;
    if (a[AW-1]) e = m_vec;
    else if (a[AW-2:0] == '0) begin
      e = {m_csr[31:4], cpu_id};
      e[16] = e[16] ^ m_lfsr[0];
      m_csr[3:0] = cpu_id;
      m_lfsr = tb_lfsr_adv(m_lfsr);
    end else begin
      e = '0; m_csr[3:0] = cpu_id;
    end
    exp_q.push_back(e); tag_q.push_back(t);
    bus(1'b0, a, 32'h0, 1'b0);
  endtask

  task automatic lines(input logic [31:0] s, input logic [31:0] c);
    m_csr = (m_csr & ~c) | s;
    if (|s && m_csr[28]) m_cirq = 1'b1;
    else if (|c && !m_csr[28]) m_cirq = 1'b0;
    @(posedge clk); #1; line_set = s; line_clr = c;
    @(posedge clk); #1; line_set = '0; line_clr = '0;
  endtask

  task automatic pulse_tick();
    if (m_csr[15]) begin m_csr[29] = 1'b1; m_tirq = 1'b1; end
    @(posedge clk); #1; tick = 1'b1;
    @(posedge clk); #1; tick = 1'b0;
  endtask

  task automatic irqs(input string t);
    @(negedge clk);
    check(cpu_irq === m_cirq, {t, " cpu_irq"}, {31'b0, cpu_irq}, {31'b0, m_cirq});
    check(timer_irq === m_tirq, {t, " timer_irq"}, {31'b0, timer_irq}, {31'b0, m_tirq});
  endtask

  logic done = 1'b0;
  initial begin
    #(5ns * 150000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state at the ports
    check(!cpu_irq && !timer_irq && !rd_valid && rd_data == 0, "R1 reset outputs",
          {28'b0, cpu_irq, timer_irq, rd_valid, |rd_data}, 32'h0);
    cpu_id = 4'h3;
    rd(A_CSR, "R1 reset word");
    rd(A_VEC, "R1 reset vector");

    // R6/R8: write loads the word including its low bits; read shows ID
    wr(A_CSR, 32'h0000_800A);
    rd(A_CSR, "R6 R8 write then read");
    // R5: tick with timer enabled
    pulse_tick();
    irqs("R5 tick enabled");
    rd(A_CSR, "R5 pending bit");
    // R6: write acknowledges the timer
    wr(A_CSR, 32'h2000_8000);
    irqs("R6 ack");
    rd(A_CSR, "R6 bit29 forced low");
    // R7: tick and write together
    pulse_tick();
    irqs("R7 pre");
    m_csr = 32'h0000_8005; m_tirq = 1'b0; m_csr[29] = 1'b0;
    bus(1'b1, A_CSR, 32'h0000_8005, 1'b1);
    irqs("R7 write wins");
    rd(A_CSR, "R7 word");
    // R5: tick with timer disabled
    wr(A_CSR, 32'h0);
    pulse_tick();
    irqs("R5 tick disabled");

    // R2/R3: set with enable clear leaves cpu_irq low
    lines(32'h0000_0020, 32'h0);
    irqs("R3 set no enable");
    rd(A_CSR, "R2 bit5 set");
    // R4: writing the enable alone does not raise cpu_irq
    wr(A_CSR, 32'h1000_0020);
    irqs("R4 hold on write");
    lines(32'h0000_0080, 32'h0);
    irqs("R3 raise");
    lines(32'h0, 32'h0000_0080);
    irqs("R4 clear with enable keeps irq");
    rd(A_CSR, "R2 bit7 cleared");
    wr(A_CSR, 32'h0000_0020);
    irqs("R4 hold after enable off");
    lines(32'h0, 32'h0000_0020);
    irqs("R4 drop");
    // R3: line 28 itself sets the enable and raises cpu_irq
    lines(32'h1000_0000, 32'h0000_0000);
    irqs("R3 line28 raise");
    lines(32'h0000_0001, 32'h1000_0000);
    irqs("R4 line28 cleared drops");
    rd(A_CSR, "R2 mixed pulses");

    // R8: different IDs on reads
    cpu_id = 4'hC; rd(A_CSR, "R8 id C");
    cpu_id = 4'h7; rd(A_CSR, "R8 id 7");
    // R9: jitter sequence over many reads
    for (int i = 0; i < 24; i++) rd(A_CSR, "R9 jitter");

    // R10: vector window
    wr(A_VEC, 32'h0000_00FC); rd(A_VEC, "R10 transmit code");
    wr(A_VEC, 32'h0000_00F8); rd(A_VEC, "R10 receive code");
    wr(A_VEC, 32'h0000_0080); rd(A_VEC, "R10 ipi code");
    rd(A_CSR, "R10 word untouched");

    // R11: unimplemented offsets
    cpu_id = 4'h9;
    rd(A_GAP, "R11 gap reads zero");
    wr(A_GAP, 32'hFFFF_FFFF);
    rd(A_CSR, "R11 gap write ignored");
    rd(13'h0FFC, "R11 last gap reads zero");

    repeat (4) @(posedge clk);
    @(negedge clk);
    // R12: no pending reads remain and no stray valid
    check(exp_q.size() == 0, "R12 queue drained", exp_q.size(), 32'h0);
    check(!rd_valid, "R12 idle", {31'b0, rd_valid}, 32'h0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule